// File: doc/BRIEF.md
# Parallel Flash Bus Front-End

This block is the device side of a byte-wide parallel NOR flash bus, built as a synchronous model. Three active-low strobes come from the external bus: chip-enable, output-enable and write-enable. Together with the 19-bit address, the write data and an identifier-mode request, they pass through a two-flop synchroniser into the system clock domain. The block then classifies each bus cycle as a read, a write, standby or output-disable, and it drives the 8-bit data bus only during a genuine read. Tri-state is modelled as a data output plus a drive-enable.

Each write loads a command latch that has no address of its own. The address is taken when the second of chip-enable and write-enable goes low. The data is taken when the first of them goes high. When the data capture completes, the address, the data and the 64 KB sector index go to a downstream command state machine with a one-cycle valid pulse.

A read returns one of three things. It returns a status byte while the downstream machine is busy. It returns a manufacturer or device code while identifier mode is requested. Otherwise it returns a byte from a small internal array.

Top module: `flash_bus_front`

## Requirements
- R1: The bus is driven (`dq_oe`=1) only when chip-enable and output-enable are both low. Whenever `dq_oe`=0, `dq_out` is 0x00. The outputs follow the bus pins after three clock edges.
- R2: A write is recognised only while write-enable and chip-enable are low and output-enable is high. A cycle in which output-enable falls before either strobe rises is dropped. The bus is never driven during a write.
- R3: The command address is the address present when the later of the chip-enable and write-enable falling edges occurs. Later address changes are ignored.
- R4: The command data is the data present when the earlier of the chip-enable and write-enable rising edges occurs. The later rising edge starts no second command.
- R5: Each completed write raises `cmd_valid` for exactly one clock cycle. `cmd_addr`, `cmd_data` and `cmd_sector` hold until the next completed write.
- R6: While chip-enable is high the bus is not driven, whatever the states of output-enable and busy.
- R7: In identifier mode, address bits [1:0]=00 read MFR_CODE (default 0xC2), 01 read DEV_CODE (default 0x4E), and 1x read 0x00. All other address bits are ignored.
- R8: `cmd_sector` equals bits [18:16] of the captured command address.
- R9: While `busy` is high, a read returns `status` in place of array or identifier data.
- R10: An array read at address A returns (idx*37 + 90) mod 256, where idx is A modulo ARRAY_DEPTH (default 64).
- R11: After reset, `dq_oe`=0, `dq_out`=0x00 and `cmd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip-enable strobe, active low |
| oe_n | input | 1 | Output-enable strobe, active low |
| we_n | input | 1 | Write-enable strobe, active low |
| addr | input | 19 | Bus address |
| dq_in | input | 8 | Data from bus (write data) |
| dq_out | output | 8 | Data to bus (read data) |
| dq_oe | output | 1 | Bus drive enable; 0 means high impedance |
| id_mode | input | 1 | Identifier-mode request |
| busy | input | 1 | Downstream command machine busy |
| status | input | 8 | Status byte returned during busy |
| cmd_valid | output | 1 | One-cycle pulse: a command was latched |
| cmd_addr | output | 19 | Latched command address |
| cmd_data | output | 8 | Latched command data |
| cmd_sector | output | 3 | Sector index of the latched address |

## Verification
The hardest cases to reach are the ones where the two capture edges come from different strobes. In one, the address must come from the moment write-enable falls after chip-enable has been low for a while. In the other, the data must come from a chip-enable rise that happens while write-enable is still low. The stimulus reaches these cases by changing the address or data on the same cycle as the deciding strobe edge, and changing it again between the two edges, so that a capture at the wrong edge yields a different value. A write abandoned by output-enable falling mid-cycle is also driven explicitly, and the bench confirms that no command pulse follows.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;

    localparam int ADDR_W = 19;
    localparam int DATA_W = 8;
    localparam int SECT_W = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    // One synchronised snapshot of the external bus
    typedef struct packed {
        logic  ce_n;
        logic  oe_n;
        logic  we_n;
        logic  id_sel;
        addr_t addr;
        data_t data;
    } bus_sample_t;

    // Command handed to the downstream state machine
    typedef struct packed {
        addr_t             addr;
        data_t             data;
        logic [SECT_W-1:0] sector;
    } cmd_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_ARRAY,
        SRC_IDENT,
        SRC_STATUS
    } rd_src_e;

    // Content of the modelled array cell at index i
    function automatic data_t fill_byte(int unsigned i);
        logic [31:0] v;
        v = i * 37 + 90;
        return v[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
    parameter int           W       = 8,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= RST_VAL;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/write_capture.sv
module write_capture
    import flash_bus_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  bus_sample_t smp,
    output logic        wr_act,
    output logic        cmd_valid,
    output cmd_t        cmd
);
    logic  act_q;
    addr_t addr_q;
    logic  strobe_up;

    // Write window: both strobes low, output-enable high
    assign wr_act    = !smp.ce_n && !smp.we_n && smp.oe_n;
    assign strobe_up = smp.ce_n || smp.we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q     <= 1'b0;
            addr_q    <= '0;
            cmd_valid <= 1'b0;
            cmd       <= '0;
        end else begin
            act_q     <= wr_act;
            cmd_valid <= 1'b0;
            // later falling edge opens the window: take the address
            if (wr_act && !act_q) begin
                addr_q <= smp.addr;
            end
            // earlier rising edge closes it: take the data
            if (!wr_act && act_q && strobe_up) begin
                cmd.addr   <= addr_q;
                cmd.data   <= smp.data;
                cmd.sector <= addr_q[ADDR_W-1 -: SECT_W];
                cmd_valid  <= 1'b1;
            end
        end
    end

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

endmodule

// File: rtl/read_path.sv
module read_path
    import flash_bus_pkg::*;
#(
    parameter int    DEPTH    = 64,
    parameter int    IDX_W    = 6,
    parameter data_t MFR_CODE = 8'hC2,
    parameter data_t DEV_CODE = 8'h4E
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic             id_sel,
    input  logic             busy,
    input  data_t            status,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       id_bits,
    output data_t            dq_out,
    output logic             dq_oe
);
    data_t   mem [DEPTH];
    rd_src_e src;
    data_t   id_byte;
    data_t   rd_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= fill_byte(i);
        end
    end

    always_comb begin
        if (!rd_en)      src = SRC_NONE;
        else if (busy)   src = SRC_STATUS;
        else if (id_sel) src = SRC_IDENT;
        else             src = SRC_ARRAY;
    end

    always_comb begin
        case (id_bits)
            2'b00:   id_byte = MFR_CODE;
            2'b01:   id_byte = DEV_CODE;
            default: id_byte = '0;
        endcase
    end

    always_comb begin
        case (src)
            SRC_STATUS: rd_byte = status;
            SRC_IDENT:  rd_byte = id_byte;
            SRC_ARRAY:  rd_byte = mem[idx];
            default:    rd_byte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_oe  <= 1'b0;
            dq_out <= '0;
        end else begin
            dq_oe  <= rd_en;
            dq_out <= rd_byte;
        end
    end

    // R1
    quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !dq_oe |-> (dq_out == '0));

endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
    import flash_bus_pkg::*;
#(
    parameter int    ARRAY_DEPTH = 64,
    parameter int    SYNC_STAGES = 2,
    parameter data_t MFR_CODE    = 8'hC2,
    parameter data_t DEV_CODE    = 8'h4E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic              id_mode,
    input  logic              busy,
    input  logic [DATA_W-1:0] status,
    output logic              cmd_valid,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic [SECT_W-1:0] cmd_sector
);
    localparam int IDX_W = $clog2(ARRAY_DEPTH);
    localparam int SMP_W = $bits(bus_sample_t);
    localparam bus_sample_t IDLE_SMP = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                         id_sel: 1'b0, addr: '0, data: '0};

    bus_sample_t      raw_smp;
    bus_sample_t      smp;
    logic [SMP_W-1:0] smp_q;
    logic             rd_en;
    logic             wr_act;
    cmd_t             cmd_q;

    assign raw_smp = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n,
                       id_sel: id_mode, addr: addr, data: dq_in};

    // strobes, address and data travel together so they stay aligned
    bus_sync #(
        .W       (SMP_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IDLE_SMP)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_smp),
        .q   (smp_q)
    );

    assign smp   = bus_sample_t'(smp_q);
    assign rd_en = !smp.ce_n && !smp.oe_n;

    write_capture u_wr (
        .clk       (clk),
        .rst       (rst),
        .smp       (smp),
        .wr_act    (wr_act),
        .cmd_valid (cmd_valid),
        .cmd       (cmd_q)
    );

    read_path #(
        .DEPTH    (ARRAY_DEPTH),
        .IDX_W    (IDX_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .id_sel  (smp.id_sel),
        .busy    (busy),
        .status  (status),
        .idx     (smp.addr[IDX_W-1:0]),
        .id_bits (smp.addr[1:0]),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe)
    );

    assign cmd_addr   = cmd_q.addr;
    assign cmd_data   = cmd_q.data;
    assign cmd_sector = cmd_q.sector;

    // R2
    no_drive_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_act |=> !dq_oe);

    // R6
    standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        smp.ce_n |=> !dq_oe);

endmodule

// File: tb/test_flash_bus_front.sv
`timescale 1ns/1ps
module test_flash_bus_front;

    logic        clk = 1'b0;
    logic        rst;
    logic        ce_n, oe_n, we_n, id_mode, busy;
    logic [18:0] addr;
    logic [7:0]  dq_in, status;
    logic [7:0]  dq_out, cmd_data;
    logic        dq_oe, cmd_valid;
    logic [18:0] cmd_addr;
    logic [2:0]  cmd_sector;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    flash_bus_front i_flash_bus_front (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .id_mode(id_mode), .busy(busy), .status(status),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_sector(cmd_sector)
    );

    // command monitor
    int          ncmd     = 0;
    int          run      = 0;
    int          max_run  = 0;
    logic [18:0] got_addr = '0;
    logic [7:0]  got_data = '0;
    logic [2:0]  got_sect = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_valid) begin
                ncmd++;
                run++;
                if (run > max_run) max_run = run;
                got_addr = cmd_addr;
                got_data = cmd_data;
                got_sect = cmd_sector;
            end else begin
                run = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] ref_byte(input logic [18:0] a);
        int unsigned i;
        i = a % 64;
        return 8'((i * 37 + 90) % 256);
    endfunction

    typedef struct packed {
        logic        id;
        logic        bsy;
        logic [18:0] a;
        logic        ce;
        logic        oe;
        logic [7:0]  st;
        logic        use_arr;
        logic        exp_oe;
        logic [7:0]  exp_d;
        logic [3:0]  req;
    } rvec_t;

    localparam int NV = 14;
    localparam rvec_t RV [NV] = '{
        '{1'b0, 1'b0, 19'h00000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 4'd10}, // R10
        '{1'b0, 1'b0, 19'h00005, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 4'd10}, // R10
        '{1'b0, 1'b0, 19'h70005, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 4'd10}, // R10 alias
        '{1'b0, 1'b0, 19'h0003F, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 4'd10}, // R10
        '{1'b1, 1'b0, 19'h00000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'hC2, 4'd7},  // R7
        '{1'b1, 1'b0, 19'h55A3C, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'hC2, 4'd7},  // R7
        '{1'b1, 1'b0, 19'h00001, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h4E, 4'd7},  // R7
        '{1'b1, 1'b0, 19'h7FFF1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h4E, 4'd7},  // R7
        '{1'b1, 1'b0, 19'h00002, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 4'd7},  // R7
        '{1'b0, 1'b1, 19'h00005, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 8'hA5, 4'd9},  // R9
        '{1'b1, 1'b1, 19'h00001, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 8'h3C, 4'd9},  // R9
        '{1'b0, 1'b0, 19'h00005, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd6},  // R6
        '{1'b0, 1'b0, 19'h00005, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 4'd1},  // R1
        '{1'b0, 1'b1, 19'h00005, 1'b1, 1'b1, 8'h77, 1'b0, 1'b0, 8'h00, 4'd6}   // R6
    };

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int exp_n;
        rst = 1'b1; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        id_mode = 1'b0; busy = 1'b0; status = '0; addr = '0; dq_in = '0;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R11 reset state
        chk(dq_oe == 1'b0,     "R11", "dq_oe",     dq_oe,     0);
        chk(dq_out == 8'h00,   "R11", "dq_out",    dq_out,    0);
        chk(cmd_valid == 1'b0, "R11", "cmd_valid", cmd_valid, 0);

        // read vectors
        for (int v = 0; v < NV; v++) begin
            logic [7:0] e;
            id_mode = RV[v].id; busy = RV[v].bsy; addr = RV[v].a;
            ce_n = RV[v].ce; oe_n = RV[v].oe; status = RV[v].st; we_n = 1'b1;
            idle(4);
            e = RV[v].use_arr ? ref_byte(RV[v].a) : RV[v].exp_d;
            chk(dq_oe == RV[v].exp_oe, $sformatf("R%0d", RV[v].req),
                $sformatf("vec %0d dq_oe", v), dq_oe, RV[v].exp_oe);
            chk(dq_out == e, $sformatf("R%0d", RV[v].req),
                $sformatf("vec %0d dq_out", v), dq_out, e);
        end
        ce_n = 1'b1; oe_n = 1'b1; busy = 1'b0; id_mode = 1'b0;
        idle(4);

        // R1 latency: outputs change on the third edge, not before
        addr = 19'h00005; ce_n = 1'b0; oe_n = 1'b0;
        idle(2);
        chk(dq_oe == 1'b0, "R1", "dq_oe after 2 edges", dq_oe, 0);
        idle(1);
        chk(dq_oe == 1'b1, "R1", "dq_oe after 3 edges", dq_oe, 1);
        ce_n = 1'b1; oe_n = 1'b1;
        idle(4);

        // basic write-enable controlled write: R2 R5 R8
        exp_n = ncmd + 1;
        ce_n = 1'b0; oe_n = 1'b1; addr = 19'h31234; dq_in = 8'h5C;
        idle(3);
        we_n = 1'b0;
        idle(4);
        chk(dq_oe == 1'b0, "R2", "dq_oe during write", dq_oe, 0);
        we_n = 1'b1;
        idle(4);
        ce_n = 1'b1;
        idle(4);
        chk(ncmd == exp_n,        "R5", "command count", ncmd, exp_n);
        chk(got_addr == 19'h31234, "R5", "cmd_addr", got_addr, 19'h31234);
        chk(got_data == 8'h5C,     "R5", "cmd_data", got_data, 8'h5C);
        chk(got_sect == 3'd3,      "R8", "cmd_sector", got_sect, 3);
        chk(cmd_addr == 19'h31234, "R5", "cmd_addr held", cmd_addr, 19'h31234);

        // R3 address at the later falling edge (write-enable falls last)
        exp_n = ncmd + 1;
        ce_n = 1'b0; addr = 19'h10AAA;
        idle(4);
        addr = 19'h60F0F; we_n = 1'b0;
        idle(4);
        addr = 19'h22222;
        idle(4);
        dq_in = 8'h81; we_n = 1'b1;
        idle(4);
        ce_n = 1'b1;
        idle(4);
        chk(ncmd == exp_n,         "R3", "command count", ncmd, exp_n);
        chk(got_addr == 19'h60F0F, "R3", "cmd_addr", got_addr, 19'h60F0F);
        chk(got_sect == 3'd6,      "R8", "cmd_sector", got_sect, 6);
        chk(got_data == 8'h81,     "R4", "cmd_data", got_data, 8'h81);

        // R4 data at the earlier rising edge (chip-enable rises first)
        exp_n = ncmd + 1;
        ce_n = 1'b0; we_n = 1'b0; addr = 19'h50001; dq_in = 8'h11;
        idle(4);
        dq_in = 8'hE7; ce_n = 1'b1;
        idle(4);
        dq_in = 8'h99;
        idle(4);
        we_n = 1'b1;
        idle(4);
        chk(ncmd == exp_n,         "R4", "single command", ncmd, exp_n);
        chk(got_data == 8'hE7,     "R4", "cmd_data", got_data, 8'hE7);
        chk(got_addr == 19'h50001, "R3", "cmd_addr", got_addr, 19'h50001);

        // R2 output-enable low: no write
        exp_n = ncmd;
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = 19'h7ABCD; dq_in = 8'h42;
        idle(4);
        we_n = 1'b1;
        idle(4);
        ce_n = 1'b1; oe_n = 1'b1;
        idle(4);
        chk(ncmd == exp_n, "R2", "no command with oe low", ncmd, exp_n);

        // R2 chip-enable high: no write
        we_n = 1'b0; addr = 19'h12345; dq_in = 8'h24;
        idle(4);
        we_n = 1'b1;
        idle(4);
        chk(ncmd == exp_n, "R2", "no command with ce high", ncmd, exp_n);

        // R2 output-enable falls mid-write: cycle dropped
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 19'h44444; dq_in = 8'h66;
        idle(4);
        oe_n = 1'b0;
        idle(4);
        we_n = 1'b1; ce_n = 1'b1;
        idle(2);
        oe_n = 1'b1;
        idle(4);
        chk(ncmd == exp_n, "R2", "aborted write dropped", ncmd, exp_n);
        chk(got_data == 8'hE7, "R5", "cmd_data held", got_data, 8'hE7);

        // R5 pulse width over all writes
        chk(max_run == 1, "R5", "cmd_valid pulse width", max_run, 1);

        finish_run();
    end

endmodule